// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Bank

This block is a general-purpose I/O peripheral that sits on a simple word-wide register bus. A request is one cycle: `bus_sel` with `bus_we` high writes, `bus_sel` with `bus_we` low reads, and read data appears on `bus_rdata` in the following cycle. Software drives pins by loading an output latch, either whole through the data register or atomically, bit by bit, through separate set and clear registers. A direction register chooses which pins drive. Pin inputs are brought into the clock domain through two flops before they can be read back.

Build-time parameters choose the register width, and with it the pin count. They also choose whether a 1 in the direction register means output or input, whether pin numbering runs in reverse across the register, and whether bytes are swapped between the bus and the register. Every register is kept in register-bit order. Bit reversal is applied only at the pin boundary and byte swapping only at the bus boundary, so both mappings are pure wiring. The access decode is a small enumerated register selector (data, set, clear, direction). The block has no sequencing state beyond its registers: each bus cycle is either idle, a write to one selected register, or a read of one selected register.

Top module: `gpio_regbank`

## Requirements
- R1: On reset the output latch is all zeros and every pin is an input (`pin_oe` all zeros). The direction register reads all zeros when a 1 means output, and all ones when a 1 means input.
- R2: A write to word address 0 (data) loads the output latch with the written word.
- R3: A write to word address 1 (set) ORs the written mask into the latch. Bits written as 0 leave their pins unchanged, so an all-zero mask changes nothing.
- R4: A write to word address 2 (clear) clears each latch bit whose written bit is 1. Bits written as 0 are unchanged.
- R5: Set and clear writes apply in bus order. A set followed by a clear of the same bit leaves that bit 0.
- R6: With `DIR_IN_POL`=0, a 1 in the direction register (word address 3) makes the matching pin an output.
- R7: With `DIR_IN_POL`=1, a 1 in the direction register makes the matching pin an input, and a 0 makes it an output.
- R8: A read of the data register returns the pin inputs as sampled through a two-flop synchronizer. An input change is visible to a read issued three cycles later.
- R9: A read of the set register returns the current output latch value.
- R10: With `BIT_REV`=1, pin n corresponds to register bit `REG_W`-1-n for output, output-enable and input alike.
- R11: With `BYTE_SWAP`=1, bus byte k corresponds to register byte `REG_W`/8-1-k on writes and reads. Byte swap is accepted only for 16- and 32-bit widths, and a width other than 8, 16, 32 or 64 is rejected at elaboration.
- R12: Read data is registered: it appears the cycle after the read request and holds while no read is issued. A read of the clear register returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 data, 1 set, 2 clear, 3 direction |
| bus_wdata | input | REG_W | Write data in bus byte order |
| bus_rdata | output | REG_W | Registered read data in bus byte order |
| pin_in | input | REG_W | Pin input levels, pin order |
| pin_out | output | REG_W | Pin output levels, pin order |
| pin_oe | output | REG_W | Pin output enables, 1 = drive |

## Verification
The hardest case to reach is the point where all three mappings act at once. Reversed pin numbering, swapped bytes and inverted direction polarity must line up across the write path, the read path and the pin path. A wrong stage cancels out only when it is wrong in the same way on both sides. A second instance is therefore built at 16 bits with every option on. Values are chosen so that a single pin lands in a different byte and a different bit position on each side, and the pin levels are checked as well as the bus readback. The input path on the default instance is reached by looping driven pins back to their inputs, so a read returns a mix of driven and external levels.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Word addresses of the register file
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_SET  = 2'd1,
        SEL_CLR  = 2'd2,
        SEL_DIR  = 2'd3
    } gpio_reg_e;

    // One-hot write strobes into the control registers
    typedef struct packed {
        logic load;
        logic set;
        logic clr;
        logic dir;
    } gpio_wr_t;

endpackage

// File: rtl/gpio_byte_map.sv
// Bus <-> register byte ordering; the swap is its own inverse.
module gpio_byte_map #(
    parameter int W    = 32,
    parameter bit SWAP = 0
) (
    input  logic [W-1:0] src,
    output logic [W-1:0] dst
);
    localparam int NBYTES = W / 8;

    generate
        if (SWAP) begin : g_swap
            for (genvar k = 0; k < NBYTES; k++) begin : g_byte
                assign dst[8*k +: 8] = src[8*(NBYTES-1-k) +: 8];
            end
        end else begin : g_pass
            assign dst = src;
        end
    endgenerate
endmodule

// File: rtl/gpio_lane_map.sv
// Pin <-> register bit numbering; the reversal is its own inverse.
module gpio_lane_map #(
    parameter int W   = 32,
    parameter bit REV = 0
) (
    input  logic [W-1:0] src,
    output logic [W-1:0] dst
);
    generate
        for (genvar n = 0; n < W; n++) begin : g_lane
            if (REV) begin : g_rev
                assign dst[n] = src[W-1-n];
            end else begin : g_fwd
                assign dst[n] = src[n];
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_sync.sv
// Two-flop input synchronizer, pin order.
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;
    logic [1:0]   age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
            age_q    <= 2'd0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
            if (age_q != 2'd2) begin
                age_q <= age_q + 2'd1;
            end
        end
    end

    assign sync_out = stage2_q;

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (sync_out == $past(async_in, 2))); // R8
endmodule

// File: rtl/gpio_ctrl_regs.sv
// Output latch and direction register, register-bit order.
module gpio_ctrl_regs
    import gpio_pkg::*;
#(
    parameter int W          = 32,
    parameter bit DIR_IN_POL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  gpio_wr_t     wr,
    input  logic [W-1:0] wword,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] oe_reg
);
    // All pins input after reset, whichever polarity is built
    localparam logic [W-1:0] DIR_RST = DIR_IN_POL ? {W{1'b1}} : {W{1'b0}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (wr.load) begin
            latch_q <= wword;
        end else if (wr.set) begin
            latch_q <= latch_q | wword;
        end else if (wr.clr) begin
            latch_q <= latch_q & ~wword;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= DIR_RST;
        end else if (wr.dir) begin
            dir_q <= wword;
        end
    end

    generate
        if (DIR_IN_POL) begin : g_dir_in
            assign oe_reg = ~dir_q;
        end else begin : g_dir_out
            assign oe_reg = dir_q;
        end
    endgenerate

    AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        wr.load |=> (latch_q == $past(wword))); // R2
    AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.set && !wr.load) |=> (latch_q == ($past(latch_q) | $past(wword)))); // R3
    AST_CLR_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.clr && !wr.load && !wr.set) |=> (latch_q == ($past(latch_q) & ~$past(wword)))); // R4
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr.load || wr.set || wr.clr) |=> $stable(latch_q)); // R3
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr.dir |=> $stable(dir_q)); // R6
    AST_RST_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (oe_reg == '0 && latch_q == '0)); // R1
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr.load, wr.set, wr.clr, wr.dir})); // R12
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_pkg::*;
#(
    parameter int REG_W      = 32,
    parameter bit BIT_REV    = 0,
    parameter bit BYTE_SWAP  = 0,
    parameter bit DIR_IN_POL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic [REG_W-1:0] pin_in,
    output logic [REG_W-1:0] pin_out,
    output logic [REG_W-1:0] pin_oe
);
    localparam bit WIDTH_OK = (REG_W == 8) || (REG_W == 16) || (REG_W == 32) || (REG_W == 64);
    localparam bit SWAP_OK  = !BYTE_SWAP || (REG_W == 16) || (REG_W == 32);

    generate
        if (!WIDTH_OK) begin : g_bad_width
            $error("gpio_regbank: REG_W must be 8, 16, 32 or 64");
        end
        if (!SWAP_OK) begin : g_bad_swap
            $error("gpio_regbank: byte swap needs a 16- or 32-bit width");
        end
    endgenerate

    gpio_reg_e          sel;
    gpio_wr_t           wr;
    logic [REG_W-1:0]   wword;
    logic [REG_W-1:0]   latch_q;
    logic [REG_W-1:0]   dir_q;
    logic [REG_W-1:0]   oe_reg;
    logic [REG_W-1:0]   in_pins;
    logic [REG_W-1:0]   in_reg;
    logic [REG_W-1:0]   rd_word;
    logic [REG_W-1:0]   rd_bus;
    logic [REG_W-1:0]   rdata_q;
    logic               rd_req;

    assign sel    = gpio_reg_e'(bus_addr);
    assign rd_req = bus_sel && !bus_we;

    // Bus byte order -> register byte order
    gpio_byte_map #(.W(REG_W), .SWAP(BYTE_SWAP)) u_wr_bytes (
        .src (bus_wdata),
        .dst (wword)
    );

    // Write decode
    always_comb begin
        wr = '0;
        if (bus_sel && bus_we) begin
            unique case (sel)
                SEL_DATA: wr.load = 1'b1;
                SEL_SET:  wr.set  = 1'b1;
                SEL_CLR:  wr.clr  = 1'b1;
                SEL_DIR:  wr.dir  = 1'b1;
            endcase
        end
    end

    gpio_ctrl_regs #(.W(REG_W), .DIR_IN_POL(DIR_IN_POL)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr),
        .wword   (wword),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .oe_reg  (oe_reg)
    );

    // Register bit order -> pin order
    gpio_lane_map #(.W(REG_W), .REV(BIT_REV)) u_out_lanes (
        .src (latch_q),
        .dst (pin_out)
    );

    gpio_lane_map #(.W(REG_W), .REV(BIT_REV)) u_oe_lanes (
        .src (oe_reg),
        .dst (pin_oe)
    );

    gpio_sync #(.W(REG_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (in_pins)
    );

    gpio_lane_map #(.W(REG_W), .REV(BIT_REV)) u_in_lanes (
        .src (in_pins),
        .dst (in_reg)
    );

    // Read select
    always_comb begin
        unique case (sel)
            SEL_DATA: rd_word = in_reg;
            SEL_SET:  rd_word = latch_q;
            SEL_CLR:  rd_word = '0;
            SEL_DIR:  rd_word = dir_q;
        endcase
    end

    gpio_byte_map #(.W(REG_W), .SWAP(BYTE_SWAP)) u_rd_bytes (
        .src (rd_word),
        .dst (rd_bus)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_req) begin
            rdata_q <= rd_bus;
        end
    end

    assign bus_rdata = rdata_q;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(bus_rdata)); // R12
    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && bus_addr == 2'd2) |=> (bus_rdata == '0)); // R12
    AST_SET_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && bus_addr == 2'd1 && BYTE_SWAP == 0 && BIT_REV == 0)
            |=> (bus_rdata == $past(pin_out))); // R9
endmodule

// File: tb/sim_gpio_regbank.sv
module sim_gpio_regbank;
    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel0 = 1'b0;
    logic        sel1 = 1'b0;
    logic        bwe = 1'b0;
    logic [1:0]  baddr = 2'd0;
    logic [31:0] bwdata = '0;
    logic [31:0] rdata0;
    logic [15:0] rdata1;
    logic [31:0] pout0, poe0, pin0;
    logic [31:0] ext0 = '0;
    logic [15:0] pout1, poe1;
    logic [15:0] pin1 = '0;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    // Driven pins loop back, undriven pins take the external level
    assign pin0 = (poe0 & pout0) | (~poe0 & ext0);

    gpio_regbank u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel0), .bus_we(bwe), .bus_addr(baddr),
        .bus_wdata(bwdata), .bus_rdata(rdata0),
        .pin_in(pin0), .pin_out(pout0), .pin_oe(poe0)
    );

    gpio_regbank #(.REG_W(16), .BIT_REV(1), .BYTE_SWAP(1), .DIR_IN_POL(1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel1), .bus_we(bwe), .bus_addr(baddr),
        .bus_wdata(bwdata[15:0]), .bus_rdata(rdata1),
        .pin_in(pin1), .pin_out(pout1), .pin_oe(poe1)
    );

    // {addr, wdata, expected pin_out, expected pin_oe} for u0
    localparam int NV = 10;
    localparam logic [97:0] VEC [NV] = '{
        {2'd0, 32'h0000_00F0, 32'h0000_00F0, 32'h0000_0000}, // R2 load
        {2'd1, 32'h0F0F_0000, 32'h0F0F_00F0, 32'h0000_0000}, // R3 set
        {2'd2, 32'h0000_00F0, 32'h0F0F_0000, 32'h0000_0000}, // R4 clear
        {2'd1, 32'h0000_0000, 32'h0F0F_0000, 32'h0000_0000}, // R3 zero mask
        {2'd2, 32'h0000_0000, 32'h0F0F_0000, 32'h0000_0000}, // R4 zero mask
        {2'd0, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 32'h0000_0000}, // R2 reload
        {2'd2, 32'hFFFF_0000, 32'h0000_A5A5, 32'h0000_0000}, // R4 upper half
        {2'd3, 32'hFFFF_0000, 32'h0000_A5A5, 32'hFFFF_0000}, // R6 outputs
        {2'd1, 32'h0001_0000, 32'h0001_A5A5, 32'hFFFF_0000}, // R5 set first
        {2'd2, 32'h0001_0000, 32'h0000_A5A5, 32'hFFFF_0000}  // R5 clear after
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit unit, input bit we, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        sel0   = !unit;
        sel1   = unit;
        bwe    = we;
        baddr  = a;
        bwdata = d;
        @(negedge clk);
        sel0 = 1'b0;
        sel1 = 1'b0;
        bwe  = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state, both polarities
        check("R1 u0 out", pout0, 32'h0);
        check("R1 u0 oe", poe0, 32'h0);
        check("R1 u1 oe", {16'h0, poe1}, 32'h0);
        access(1'b0, 1'b0, 2'd3, '0);
        check("R1 u0 dir read", rdata0, 32'h0);
        access(1'b1, 1'b0, 2'd3, '0);
        check("R1 R7 u1 dir read", {16'h0, rdata1}, 32'h0000_FFFF);

        // Vector table on u0
        for (int i = 0; i < NV; i++) begin
            access(1'b0, 1'b1, VEC[i][97:96], VEC[i][95:64]);
            check($sformatf("R2-5 vec%0d out", i), pout0, VEC[i][63:32]);
            check($sformatf("R6 vec%0d oe", i), poe0, VEC[i][31:0]);
        end

        // R9 set register reads the latch
        access(1'b0, 1'b0, 2'd1, '0);
        check("R9 set readback", rdata0, 32'h0000_A5A5);

        // R8 synchronized input, mixed driven and external pins
        ext0 = 32'h1234_5678;
        idle(3);
        access(1'b0, 1'b0, 2'd0, '0);
        check("R8 data read", rdata0, 32'h0000_5678);

        // R12 clear reads zero, read data holds when idle
        access(1'b0, 1'b0, 2'd2, '0);
        check("R12 clear read", rdata0, 32'h0);
        access(1'b0, 1'b0, 2'd3, '0);
        check("R6 dir read", rdata0, 32'hFFFF_0000);
        ext0 = 32'h0;
        idle(4);
        check("R12 rdata hold", rdata0, 32'hFFFF_0000);

        // R10 R11 u1: bus 0x0001 -> reg bit 8 -> pin 7
        access(1'b1, 1'b1, 2'd0, 32'h0000_0001);
        check("R10 R11 u1 out", {16'h0, pout1}, 32'h0000_0080);
        check("R7 u1 still input", {16'h0, poe1}, 32'h0);
        // R7 reg bit 8 = 0 -> pin 7 output; reg 0xFEFF is bus 0xFFFE
        access(1'b1, 1'b1, 2'd3, 32'h0000_FFFE);
        check("R7 u1 oe", {16'h0, poe1}, 32'h0000_0080);
        access(1'b1, 1'b0, 2'd1, '0);
        check("R9 R11 u1 set read", {16'h0, rdata1}, 32'h0000_0001);
        // pin 0 -> reg bit 15 -> bus 0x0080
        pin1 = 16'h0001;
        idle(3);
        access(1'b1, 1'b0, 2'd0, '0);
        check("R10 u1 in pin0", {16'h0, rdata1}, 32'h0000_0080);
        // pin 8 -> reg bit 7 -> bus 0x8000
        pin1 = 16'h0100;
        idle(3);
        access(1'b1, 1'b0, 2'd0, '0);
        check("R10 R11 u1 in pin8", {16'h0, rdata1}, 32'h0000_8000);
        // R11 set through swapped bus: bus 0x0100 -> reg bit 0 -> pin 15
        access(1'b1, 1'b1, 2'd1, 32'h0000_0100);
        check("R3 R11 u1 set", {16'h0, pout1}, 32'h0000_8080);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule